// File: doc/BRIEF.md
# Operand and Address Size Resolver

This block works out, for each decoded instruction, how wide its data operand is and how wide its address computation is. It combines the default-size bit of the current code segment, a flag that marks 64-bit mode, the operand-size and address-size override prefix flags, the 64-bit-operand prefix bit and an opcode-derived flag that marks byte-wide instruction forms. The override prefixes are relative: each one flips its size away from the segment default instead of forcing a fixed width.

A writeback merge unit sits beside the decoder. It takes an execution result, the old contents of the destination general register and the resolved operand size, and forms the new register value. Narrow results keep part of the old register, while a 32-bit result in 64-bit mode clears the upper half. A parameter selects whether the merged value leaves through a register stage, with a one-cycle latency, or straight from logic.

Size outputs use a 2-bit code: 00 means 8 bits, 01 means 16 bits, 10 means 32 bits and 11 means 64 bits.

Top module: `opsz_resolver`

## Requirements
- R1: Outside 64-bit mode, with no prefix and a non-byte form, both sizes are 16 bits (code 01) when the segment default bit is 0 and 32 bits (code 10) when it is 1.
- R2: Outside 64-bit mode, the operand-size prefix gives an operand size of 32 bits when the default bit is 0 and 16 bits when it is 1. The 64-bit-operand prefix bit has no effect outside 64-bit mode.
- R3: Outside 64-bit mode, the address-size prefix gives 32-bit addressing when the default bit is 0 and 16-bit addressing when it is 1. The address size is never 8 or 64 bits outside 64-bit mode.
- R4: A byte-form instruction always has operand size code 00, whatever the mode, default bit or prefixes.
- R5: In 64-bit mode the operand size is 64 bits when the 64-bit-operand prefix bit is set, even if the operand-size prefix is also present. Otherwise it is 16 bits with the operand-size prefix and 32 bits without it. The segment default bit is ignored.
- R6: In 64-bit mode the address size is 64 bits, or 32 bits when the address-size prefix is present.
- R7: For an 8-bit operand size the merged register takes bits 7:0 from the result and bits 63:8 from the old value. For a 16-bit size it takes bits 15:0 from the result and bits 63:16 from the old value.
- R8: For a 32-bit operand size, bits 31:0 come from the result. Bits 63:32 are zero in 64-bit mode and keep the old value outside it. For a 64-bit size the whole result is written.
- R9: With the register stage, the merged value and its valid flag appear on the clock edge after a writeback request. Reset clears both to zero. Without a request the merged value holds and the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_def32 | input | 1 | Default-size bit of the code segment |
| long_mode | input | 1 | 64-bit mode active |
| pfx_opsz | input | 1 | Operand-size override prefix present |
| pfx_adsz | input | 1 | Address-size override prefix present |
| rex_w | input | 1 | 64-bit-operand prefix bit |
| byte_form | input | 1 | Opcode works on bytes |
| wb_valid | input | 1 | Writeback request |
| wb_result | input | 64 | Execution result |
| wb_old | input | 64 | Old destination register value |
| op_size | output | 2 | Effective operand size code |
| addr_size | output | 2 | Effective address size code |
| wb_new | output | 64 | Merged register value |
| wb_new_valid | output | 1 | Merged value valid |

## Verification
The size outputs are combinational. A wrong priority between the 64-bit-operand bit, the prefixes and the byte flag therefore shows on op_size or addr_size in the same cycle the inputs are applied. A merge lane chosen wrongly shows as corrupted upper or lower bytes of wb_new one edge after the writeback request, and the bench checks wb_new against a fixed old value and result with distinct bytes, so any swapped or missing lane appears in that sample. A stuck valid register or a failure to hold shows on the first idle cycle after a write.

// File: rtl/opsz_pkg.sv
package opsz_pkg;

    typedef enum logic [1:0] {
        SZ8  = 2'b00,
        SZ16 = 2'b01,
        SZ32 = 2'b10,
        SZ64 = 2'b11
    } size_e;

    typedef struct packed {
        logic def32;
        logic long_mode;
        logic opsz_pfx;
        logic adsz_pfx;
        logic rex_w;
        logic byte_form;
    } mode_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;

    // Legacy modes: a prefix flips the size away from the segment default.
    function automatic size_e legacy_size(logic def32, logic pfx);
        return (def32 ^ pfx) ? SZ32 : SZ16;
    endfunction

endpackage

// File: rtl/opsz_opsel.sv
module opsz_opsel
    import opsz_pkg::*;
(
    input  mode_t m,
    output size_e sz
);
    always_comb begin
        if (m.byte_form)
            sz = SZ8;
        else if (m.long_mode) begin
            if (m.rex_w)
                sz = SZ64;
            else if (m.opsz_pfx)
                sz = SZ16;
            else
                sz = SZ32;
        end else
            sz = legacy_size(m.def32, m.opsz_pfx);
    end
endmodule

// File: rtl/opsz_adsel.sv
module opsz_adsel
    import opsz_pkg::*;
(
    input  mode_t m,
    output size_e sz
);
    always_comb begin
        if (m.long_mode)
            sz = m.adsz_pfx ? SZ32 : SZ64;
        else
            sz = legacy_size(m.def32, m.adsz_pfx);
    end
endmodule

// File: rtl/opsz_merge.sv
module opsz_merge
    import opsz_pkg::*;
#(
    parameter int unsigned GPR_W = 64
) (
    input  size_e              sz,
    input  logic               long_mode,
    input  logic [GPR_W-1:0]   res,
    input  logic [GPR_W-1:0]   old,
    output logic [GPR_W-1:0]   merged
);
    localparam int unsigned UPPER_W = GPR_W - WORD_W;

    always_comb begin
        unique case (sz)
            SZ8:  merged = {old[GPR_W-1:BYTE_W], res[BYTE_W-1:0]};
            SZ16: merged = {old[GPR_W-1:HALF_W], res[HALF_W-1:0]};
            SZ32: merged = long_mode ? {{UPPER_W{1'b0}}, res[WORD_W-1:0]}
                                     : {old[GPR_W-1:WORD_W], res[WORD_W-1:0]};
            default: merged = res;
        endcase
    end
endmodule

// File: rtl/opsz_resolver.sv
module opsz_resolver
    import opsz_pkg::*;
#(
    parameter int unsigned GPR_W     = 64,
    parameter bit          MERGE_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_def32,
    input  logic             long_mode,
    input  logic             pfx_opsz,
    input  logic             pfx_adsz,
    input  logic             rex_w,
    input  logic             byte_form,
    input  logic             wb_valid,
    input  logic [GPR_W-1:0] wb_result,
    input  logic [GPR_W-1:0] wb_old,
    output logic [1:0]       op_size,
    output logic [1:0]       addr_size,
    output logic [GPR_W-1:0] wb_new,
    output logic             wb_new_valid
);
    mode_t             mode;
    size_e             op_sz;
    size_e             ad_sz;
    logic [GPR_W-1:0]  merged;

    always_comb begin
        mode.def32     = cs_def32;
        mode.long_mode = long_mode;
        mode.opsz_pfx  = pfx_opsz;
        mode.adsz_pfx  = pfx_adsz;
        mode.rex_w     = rex_w;
        mode.byte_form = byte_form;
    end

    opsz_opsel u_opsel (.m(mode), .sz(op_sz));
    opsz_adsel u_adsel (.m(mode), .sz(ad_sz));

    opsz_merge #(.GPR_W(GPR_W)) u_merge (
        .sz        (op_sz),
        .long_mode (long_mode),
        .res       (wb_result),
        .old       (wb_old),
        .merged    (merged)
    );

    assign op_size   = op_sz;
    assign addr_size = ad_sz;

    generate
        if (MERGE_REG) begin : g_reg
            logic [GPR_W-1:0] new_q;
            logic             vld_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    new_q <= '0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= wb_valid;
                    if (wb_valid)
                        new_q <= merged;
                end
            end
            assign wb_new       = new_q;
            assign wb_new_valid = vld_q;

            p_low16_keep_r7: assert property (@(posedge clk) disable iff (rst)
                (wb_valid && op_size == SZ16) |=> (wb_new[GPR_W-1:16] == $past(wb_old[GPR_W-1:16])));
            p_long32_zext_r8: assert property (@(posedge clk) disable iff (rst)
                (wb_valid && long_mode && op_size == SZ32) |=> (wb_new[GPR_W-1:32] == '0));
            p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
                !wb_valid |=> ($stable(wb_new) && !wb_new_valid));
        end else begin : g_comb
            assign wb_new       = merged;
            assign wb_new_valid = wb_valid;
        end
    endgenerate

    p_byte_form_r4: assert property (@(posedge clk) disable iff (rst)
        byte_form |-> (op_size == SZ8));
    p_wide_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (long_mode && rex_w && !byte_form) |-> (op_size == SZ64));
    p_legacy_addr_r3: assert property (@(posedge clk) disable iff (rst)
        !long_mode |-> (addr_size == SZ16 || addr_size == SZ32));
    p_long_addr_r6: assert property (@(posedge clk) disable iff (rst)
        long_mode |-> (addr_size == (pfx_adsz ? SZ32 : SZ64)));
endmodule

// File: tb/opsz_resolver_test.sv
module opsz_resolver_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_def32 = 0, long_mode = 0, pfx_opsz = 0, pfx_adsz = 0;
    logic        rex_w = 0, byte_form = 0, wb_valid = 0;
    logic [63:0] wb_result = '0, wb_old = '0;
    logic [1:0]  op_size, addr_size;
    logic [63:0] wb_new;
    logic        wb_new_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    localparam logic [63:0] OLDV = 64'hFFEE_DDCC_BBAA_9988;
    localparam logic [63:0] RESV = 64'h0123_4567_89AB_CDEF;

    always #4 clk = ~clk;

    opsz_resolver uut (
        .clk(clk), .rst(rst), .cs_def32(cs_def32), .long_mode(long_mode),
        .pfx_opsz(pfx_opsz), .pfx_adsz(pfx_adsz), .rex_w(rex_w),
        .byte_form(byte_form), .wb_valid(wb_valid), .wb_result(wb_result),
        .wb_old(wb_old), .op_size(op_size), .addr_size(addr_size),
        .wb_new(wb_new), .wb_new_valid(wb_new_valid)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic d, logic l, logic o, logic a, logic w, logic b);
        @(negedge clk);
        cs_def32 = d; long_mode = l; pfx_opsz = o; pfx_adsz = a; rex_w = w; byte_form = b;
        #1;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset wb_new", wb_new, 64'h0);
        chk("R9 reset valid", {63'h0, wb_new_valid}, 64'h0);
        rst = 1'b0;
    endtask

    task automatic test_legacy();
        set_mode(0, 0, 0, 0, 0, 0);
        chk("R1 op d0", {62'h0, op_size}, 64'h1);
        chk("R1 ad d0", {62'h0, addr_size}, 64'h1);
        set_mode(1, 0, 0, 0, 0, 0);
        chk("R1 op d1", {62'h0, op_size}, 64'h2);
        chk("R1 ad d1", {62'h0, addr_size}, 64'h2);
        for (int i = 0; i < 16; i++) begin
            logic d, o, a, w;
            {d, o, a, w} = 4'(i);
            set_mode(d, 0, o, a, w, 0);
            chk("R2 legacy op", {62'h0, op_size}, (d ^ o) ? 64'h2 : 64'h1);
            chk("R3 legacy ad", {62'h0, addr_size}, (d ^ a) ? 64'h2 : 64'h1);
        end
    endtask

    task automatic test_long();
        for (int i = 0; i < 16; i++) begin
            logic d, o, a, w;
            {d, o, a, w} = 4'(i);
            set_mode(d, 1, o, a, w, 0);
            chk("R5 long op", {62'h0, op_size}, w ? 64'h3 : (o ? 64'h1 : 64'h2));
            chk("R6 long ad", {62'h0, addr_size}, a ? 64'h2 : 64'h3);
        end
    endtask

    task automatic test_byte();
        for (int i = 0; i < 32; i++) begin
            logic d, l, o, a, w;
            {d, l, o, a, w} = 5'(i);
            set_mode(d, l, o, a, w, 1);
            chk("R4 byte op", {62'h0, op_size}, 64'h0);
        end
    endtask

    task automatic do_write(string tag, logic d, logic l, logic w, logic b, logic [63:0] exp);
        @(negedge clk);
        cs_def32 = d; long_mode = l; pfx_opsz = 0; pfx_adsz = 0; rex_w = w; byte_form = b;
        wb_old = OLDV; wb_result = RESV; wb_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wb_valid = 1'b0;
        #1;
        chk(tag, wb_new, exp);
        chk("R9 valid after write", {63'h0, wb_new_valid}, 64'h1);
    endtask

    task automatic test_merge();
        do_write("R7 merge 8",        0, 0, 0, 1, 64'hFFEE_DDCC_BBAA_99EF);
        do_write("R7 merge 16",       0, 0, 0, 0, 64'hFFEE_DDCC_BBAA_CDEF);
        do_write("R8 merge 32 long",  0, 1, 0, 0, 64'h0000_0000_89AB_CDEF);
        do_write("R8 merge 32 legacy",1, 0, 0, 0, 64'hFFEE_DDCC_89AB_CDEF);
        do_write("R8 merge 64",       0, 1, 1, 0, 64'h0123_4567_89AB_CDEF);
        // idle cycle: no request, new inputs must not disturb the output
        wb_result = 64'h5555_5555_5555_5555;
        wb_old    = 64'hAAAA_AAAA_AAAA_AAAA;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9 hold value", wb_new, 64'h0123_4567_89AB_CDEF);
        chk("R9 idle valid", {63'h0, wb_new_valid}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_legacy();
        test_long();
        test_byte();
        test_merge();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule